// File: doc/BRIEF.md
# Age-Ordered Redirect Filter

This block sits at the back end of a multithreaded out-of-order pipeline and decides which redirect requests (branch mispredictions, traps) become squash broadcasts. For every thread it keeps a bound: the sequence number of the youngest instruction that is still valid. A redirect is only meaningful if the instruction that raised it is older than that bound. Requests at or past the bound come from work that an earlier squash already removed, so they are discarded and counted.

Several request sources feed the block in parallel. Each request carries a thread ID, a sequence number, a misprediction flag and a target. Per thread, the block picks the oldest eligible request. It registers that request as a one-cycle broadcast on the thread's own output lane and moves the thread's bound to the squashing sequence number. Instruction insertions move the bound forward as new work enters the machine.

Each thread lane is a two-state machine:
- EMPTY: no instruction has been inserted since reset, and every redirect is dropped. The FIRST_INSERT transition, taken on the first valid insertion, moves the lane to TRACK.
- TRACK: the bound is live. The lane never returns to EMPTY except through reset.

Top module: `rf_redirect_filter`

## Requirements
- R1: While reset is asserted, and at its release, every squash-valid output is 0, the drop counter is 0 and every thread lane is in EMPTY.
- R2: A thread in EMPTY forwards no redirect. Every valid request addressed to it is dropped until its first valid insertion.
- R3: Each valid insertion for a thread sets that thread's bound to the inserted sequence number and moves the lane to TRACK.
- R4: A request for thread t (rd_tid field of source s, at bits [s*TID_W +: TID_W]) is forwarded only when its sequence number is strictly below thread t's bound. The broadcast appears on lane t one clock after the request, carrying the sequence number and the thread ID.
- R5: After a forwarded squash, the bound equals the squashing sequence number. A later request with an equal or larger number is dropped.
- R6: When several sources target the same thread in one cycle, only the eligible request with the smallest sequence number is forwarded. On equal numbers, the lowest source index wins.
- R7: A broadcast carries the misprediction flag of the winning request. Its target equals the request's target when the flag is 1 and is zero when the flag is 0.
- R8: When an insertion and a forwarded squash hit the same thread in the same cycle, the bound takes the squash sequence number.
- R9: Threads are filtered independently. Lanes of different threads can broadcast in the same cycle.
- R10: The drop counter adds, each cycle, the number of valid requests that were not forwarded, and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | THREADS | Per-thread insertion strobe |
| ins_seq | input | THREADS*SEQ_W | Per-thread inserted sequence number |
| rd_valid | input | SOURCES | Per-source redirect request strobe |
| rd_tid | input | SOURCES*TID_W | Per-source thread ID |
| rd_seq | input | SOURCES*SEQ_W | Per-source squashing sequence number |
| rd_mispred | input | SOURCES | Per-source misprediction flag |
| rd_target | input | SOURCES*TGT_W | Per-source corrected target |
| sq_valid | output | THREADS | Per-lane squash broadcast strobe |
| sq_seq | output | THREADS*SEQ_W | Squash-until sequence number per lane |
| sq_tid | output | THREADS*TID_W | Thread ID per lane |
| sq_mispred | output | THREADS | Misprediction flag per lane |
| sq_target | output | THREADS*TGT_W | Corrected target per lane |
| drop_count | output | DROP_W | Saturating count of dropped requests |

## Verification
The hardest case to reach from the ports is an insertion and a forwarded squash landing on one thread in the same cycle. Only a later request can show which value won the bound. The stimulus drives both in one cycle, then sends a request one above the squash number, which must be dropped, and a request one below it, which must be forwarded. The lowest-index tie-break needs two sources with equal sequence numbers but different misprediction flags, so that the winner can be told apart at the lane output.

// File: rtl/rf_pkg.sv
package rf_pkg;
    typedef enum logic {
        TH_EMPTY = 1'b0,
        TH_TRACK = 1'b1
    } th_state_e;
endpackage

// File: rtl/rf_thread_lane.sv
module rf_thread_lane
    import rf_pkg::*;
#(
    parameter int SRC       = 2,
    parameter int SEQ_W     = 16,
    parameter int TGT_W     = 32,
    parameter int TID_W     = 1,
    parameter int THREAD_ID = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ins_valid,
    input  logic [SEQ_W-1:0]       ins_seq,
    input  logic [SRC-1:0]         rd_valid,
    input  logic [SRC*TID_W-1:0]   rd_tid,
    input  logic [SRC*SEQ_W-1:0]   rd_seq,
    input  logic [SRC-1:0]         rd_mispred,
    input  logic [SRC*TGT_W-1:0]   rd_target,
    output logic                   fire,
    output logic                   sq_valid,
    output logic [SEQ_W-1:0]       sq_seq,
    output logic [TID_W-1:0]       sq_tid,
    output logic                   sq_mispred,
    output logic [TGT_W-1:0]       sq_target
);
    localparam int IDX_W = (SRC > 1) ? $clog2(SRC) : 1;
    localparam logic [TID_W-1:0] MY_TID = TID_W'(THREAD_ID);

    th_state_e        state_q, state_d;
    logic [SEQ_W-1:0] young_q, young_d;
    logic [SRC-1:0]   elig;
    logic [SEQ_W-1:0] win_seq;
    logic [IDX_W-1:0] win_idx;

    // eligibility of each source for this thread
    for (genvar s = 0; s < SRC; s++) begin : g_elig
        assign elig[s] = rd_valid[s]
                      && (rd_tid[s*TID_W +: TID_W] == MY_TID)
                      && (state_q == TH_TRACK)
                      && (rd_seq[s*SEQ_W +: SEQ_W] < young_q);
    end

    // oldest eligible request; ties keep the lower index
    always_comb begin
        fire    = 1'b0;
        win_seq = '0;
        win_idx = '0;
        for (int s = 0; s < SRC; s++) begin
            if (elig[s] && (!fire || rd_seq[s*SEQ_W +: SEQ_W] < win_seq)) begin
                fire    = 1'b1;
                win_seq = rd_seq[s*SEQ_W +: SEQ_W];
                win_idx = IDX_W'(s);
            end
        end
    end

    // next state and bound
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TH_EMPTY: if (ins_valid) state_d = TH_TRACK;   // FIRST_INSERT
            TH_TRACK: state_d = TH_TRACK;
            default:  state_d = TH_EMPTY;
        endcase
        young_d = young_q;
        if (fire)           young_d = win_seq;   // squash wins over insertion
        else if (ins_valid) young_d = ins_seq;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TH_EMPTY;
            young_q <= '0;
        end else begin
            state_q <= state_d;
            young_q <= young_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_valid   <= 1'b0;
            sq_seq     <= '0;
            sq_tid     <= '0;
            sq_mispred <= 1'b0;
            sq_target  <= '0;
        end else begin
            sq_valid <= fire;
            if (fire) begin
                sq_seq     <= win_seq;
                sq_tid     <= MY_TID;
                sq_mispred <= rd_mispred[win_idx];
                sq_target  <= rd_mispred[win_idx] ? rd_target[win_idx*TGT_W +: TGT_W] : '0;
            end
        end
    end

    a_r4_fwd_older: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |-> (sq_seq < $past(young_q)));
    a_r5_bound_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |-> (young_q == sq_seq));
    a_r2_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TH_EMPTY) |-> !sq_valid);
    a_r7_target_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && !sq_mispred) |-> (sq_target == '0));
    for (genvar s = 0; s < SRC; s++) begin : g_chk
        a_r6_oldest_wins: assert property (@(posedge clk) disable iff (!rst_n)
            elig[s] |-> (fire && (win_seq <= rd_seq[s*SEQ_W +: SEQ_W])));
    end
endmodule

// File: rtl/rf_drop_counter.sv
module rf_drop_counter #(
    parameter int W     = 8,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     count
);
    localparam int SUM_W = ((W > INC_W) ? W : INC_W) + 1;
    localparam logic [SUM_W-1:0] MAX = SUM_W'({W{1'b1}});

    logic [SUM_W-1:0] sum;
    assign sum = SUM_W'(count) + SUM_W'(inc);

    always_ff @(posedge clk) begin
        if (!rst_n)          count <= '0;
        else if (sum > MAX)  count <= '1;
        else                 count <= sum[W-1:0];
    end

    a_r10_drop_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (count >= $past(count)));
endmodule

// File: rtl/rf_redirect_filter.sv
module rf_redirect_filter #(
    parameter int THREADS = 2,
    parameter int SOURCES = 2,
    parameter int SEQ_W   = 16,
    parameter int TGT_W   = 32,
    parameter int DROP_W  = 8,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [THREADS-1:0]         ins_valid,
    input  logic [THREADS*SEQ_W-1:0]   ins_seq,
    input  logic [SOURCES-1:0]         rd_valid,
    input  logic [SOURCES*TID_W-1:0]   rd_tid,
    input  logic [SOURCES*SEQ_W-1:0]   rd_seq,
    input  logic [SOURCES-1:0]         rd_mispred,
    input  logic [SOURCES*TGT_W-1:0]   rd_target,
    output logic [THREADS-1:0]         sq_valid,
    output logic [THREADS*SEQ_W-1:0]   sq_seq,
    output logic [THREADS*TID_W-1:0]   sq_tid,
    output logic [THREADS-1:0]         sq_mispred,
    output logic [THREADS*TGT_W-1:0]   sq_target,
    output logic [DROP_W-1:0]          drop_count
);
    localparam int INC_W = $clog2(SOURCES + 1);

    logic [THREADS-1:0] fire;
    logic [INC_W-1:0]   drop_inc;

    for (genvar t = 0; t < THREADS; t++) begin : g_lane
        rf_thread_lane #(
            .SRC(SOURCES), .SEQ_W(SEQ_W), .TGT_W(TGT_W),
            .TID_W(TID_W), .THREAD_ID(t)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .ins_valid  (ins_valid[t]),
            .ins_seq    (ins_seq[t*SEQ_W +: SEQ_W]),
            .rd_valid   (rd_valid),
            .rd_tid     (rd_tid),
            .rd_seq     (rd_seq),
            .rd_mispred (rd_mispred),
            .rd_target  (rd_target),
            .fire       (fire[t]),
            .sq_valid   (sq_valid[t]),
            .sq_seq     (sq_seq[t*SEQ_W +: SEQ_W]),
            .sq_tid     (sq_tid[t*TID_W +: TID_W]),
            .sq_mispred (sq_mispred[t]),
            .sq_target  (sq_target[t*TGT_W +: TGT_W])
        );
    end

    // requests not forwarded this cycle
    always_comb begin
        int nv;
        int nf;
        nv = 0;
        nf = 0;
        for (int s = 0; s < SOURCES; s++) nv += int'(rd_valid[s]);
        for (int t = 0; t < THREADS; t++) nf += int'(fire[t]);
        drop_inc = INC_W'(nv - nf);
    end

    rf_drop_counter #(.W(DROP_W), .INC_W(INC_W)) u_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (drop_inc),
        .count (drop_count)
    );

    a_r9_lane_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fire) <= $countones(rd_valid));
endmodule

// File: tb/rf_redirect_filter_test.sv
module rf_redirect_filter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  ins_valid;
    logic [31:0] ins_seq;
    logic [1:0]  rd_valid;
    logic [1:0]  rd_tid;
    logic [31:0] rd_seq;
    logic [1:0]  rd_mispred;
    logic [63:0] rd_target;
    logic [1:0]  sq_valid;
    logic [31:0] sq_seq;
    logic [1:0]  sq_tid;
    logic [1:0]  sq_mispred;
    logic [63:0] sq_target;
    logic [7:0]  drop_count;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    rf_redirect_filter uut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_seq(ins_seq),
        .rd_valid(rd_valid), .rd_tid(rd_tid), .rd_seq(rd_seq),
        .rd_mispred(rd_mispred), .rd_target(rd_target),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_tid(sq_tid),
        .sq_mispred(sq_mispred), .sq_target(sq_target),
        .drop_count(drop_count)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        ins_valid = '0; ins_seq = '0;
        rd_valid = '0; rd_tid = '0; rd_seq = '0; rd_mispred = '0; rd_target = '0;
    endtask

    task automatic put_ins(int t, int seq);
        ins_valid[t] = 1'b1;
        ins_seq[t*16 +: 16] = 16'(seq);
    endtask

    task automatic put_rd(int s, int tid, int seq, bit mp, int tgt);
        rd_valid[s] = 1'b1;
        rd_tid[s] = 1'(tid);
        rd_seq[s*16 +: 16] = 16'(seq);
        rd_mispred[s] = mp;
        rd_target[s*32 +: 32] = 32'(tgt);
    endtask

    // one clock: inputs captured at posedge, outputs sampled at next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        clear_in();
        repeat (3) @(negedge clk);
        chk("R1", "sq_valid in reset", sq_valid, 0);
        chk("R1", "drop_count in reset", drop_count, 0);
        rst_n = 1'b1;
        step();
        chk("R1", "sq_valid after reset", sq_valid, 0);
    endtask

    task automatic t_empty();
        put_rd(0, 0, 5, 1'b1, 32'h1111);
        step(); clear_in();
        chk("R2", "no squash while empty", sq_valid, 0);
        chk("R2", "drop counted", drop_count, 1);
    endtask

    task automatic t_first_forward();
        put_ins(0, 10); put_ins(1, 20);
        step(); clear_in();
        put_rd(0, 0, 7, 1'b1, 32'hABCD);
        step(); clear_in();
        chk("R3", "lane0 forward after insert", sq_valid, 2'b01);
        chk("R4", "squash seq", sq_seq[15:0], 7);
        chk("R4", "squash tid", sq_tid[0], 0);
        chk("R7", "mispred flag", sq_mispred[0], 1);
        chk("R7", "target", sq_target[31:0], 32'hABCD);
        step();
        chk("R4", "one-cycle pulse", sq_valid, 0);
    endtask

    task automatic t_bound_moved();
        put_rd(0, 0, 8, 1'b0, 0);
        step(); clear_in();
        chk("R5", "greater seq dropped", sq_valid, 0);
        put_rd(1, 0, 7, 1'b0, 0);
        step(); clear_in();
        chk("R5", "equal seq dropped", sq_valid, 0);
        chk("R10", "drops after bound", drop_count, 3);
    endtask

    task automatic t_two_sources();
        put_rd(0, 1, 15, 1'b1, 32'h55);
        put_rd(1, 1, 12, 1'b0, 32'h66);
        step(); clear_in();
        chk("R6", "lane1 fires", sq_valid, 2'b10);
        chk("R6", "smallest seq wins", sq_seq[31:16], 12);
        chk("R4", "lane1 tid", sq_tid[1], 1);
        chk("R7", "target zero without mispred", sq_target[63:32], 0);
        chk("R10", "loser counted", drop_count, 4);
    endtask

    task automatic t_tie();
        put_ins(1, 100);
        step(); clear_in();
        put_rd(0, 1, 90, 1'b0, 32'h77);
        put_rd(1, 1, 90, 1'b1, 32'h88);
        step(); clear_in();
        chk("R6", "tie fires", sq_valid, 2'b10);
        chk("R6", "tie lower index mispred", sq_mispred[1], 0);
        chk("R6", "tie lower index target", sq_target[63:32], 0);
        chk("R10", "tie loser counted", drop_count, 5);
    endtask

    task automatic t_both_threads();
        put_ins(0, 30); put_ins(1, 40);
        step(); clear_in();
        put_rd(0, 0, 25, 1'b1, 32'h123);
        put_rd(1, 1, 35, 1'b1, 32'h456);
        step(); clear_in();
        chk("R9", "both lanes fire", sq_valid, 2'b11);
        chk("R9", "lane0 seq", sq_seq[15:0], 25);
        chk("R9", "lane1 seq", sq_seq[31:16], 35);
        chk("R9", "lane1 target", sq_target[63:32], 32'h456);
        chk("R10", "no drops", drop_count, 5);
    endtask

    task automatic t_precedence();
        put_ins(0, 50);
        put_rd(0, 0, 20, 1'b0, 0);
        step(); clear_in();
        chk("R8", "squash with insertion fires", sq_valid, 2'b01);
        put_rd(0, 0, 21, 1'b0, 0);
        step(); clear_in();
        chk("R8", "bound kept squash seq", sq_valid, 0);
        put_rd(0, 0, 19, 1'b0, 0);
        step(); clear_in();
        chk("R8", "older than squash fires", sq_valid, 2'b01);
        chk("R10", "precedence drops", drop_count, 6);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 130; i++) begin
            put_rd(0, 0, 16'hFFFF, 1'b0, 0);
            put_rd(1, 1, 16'hFFFF, 1'b0, 0);
            step();
        end
        clear_in();
        step();
        chk("R10", "drop counter saturates", drop_count, 255);
        chk("R5", "no forwards in flood", sq_valid, 0);
    endtask

    initial begin
        clear_in();
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_empty();
        t_first_forward();
        t_bound_moved();
        t_two_sources();
        t_tie();
        t_both_threads();
        t_precedence();
        t_saturate();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule